// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides floating-point conditional predicates from the condition flags of a floating-point status word. It also produces the data-register side effects of the conditional instructions built on those predicates. A status word is loaded through a write port and kept inside the block. Each request on the request strobe carries a 6-bit predicate code, an operation kind and a 32-bit data-register value. One cycle later the block returns the predicate outcome, an illegal-code flag, the rewritten data-register value and a branch-taken flag.

The predicates follow unordered-aware rules: when the not-a-number flag is set, the negative and zero flags count as clear. Every predicate is reachable through two codes, one in 0x00–0x0F and one in 0x10–0x1F. There are three operation kinds. A plain conditional branch passes the register through unchanged. A set-on-condition writes a byte mask. A counted loop decrements a 16-bit counter held in the low half of the register.

Top module: `fcc_eval`

## Requirements
- R1: After reset the stored status word is zero. A write on `stat_we` stores bits 23..0 as written and bits 27..24 as the condition flags, and forces bits 31..28 to zero. `stat_rdata` shows the stored word from the cycle after the write. The flag positions are: not-a-number at bit 24, infinity at bit 25, zero at bit 26, negative at bit 27.
- R2: With the not-a-number flag set, every predicate behaves as if both the negative and zero flags were clear, whatever their stored values. The infinity flag never affects a predicate.
- R3: Let U be not-a-number, and let Z and N be the masked zero and negative flags. For codes 0x00..0x0F the predicate is: 0x00 false, 0x0F true, 0x01 Z, 0x0E !Z, 0x07 !U, 0x08 U, 0x09 U|Z, 0x06 !(U|Z), 0x02 !(U|Z|N), 0x0D U|Z|N, 0x04 N&!(U|Z), 0x0B U|Z|!N, 0x03 Z|!(U|N), 0x0C U|(N&!Z), 0x05 Z|(N&!U), 0x0A U|!(N|Z).
- R4: Any code in 0x10..0x1F gives exactly the result of the code 0x10 lower.
- R5: A code above 0x1F sets `rsp_illegal`, and it forces `rsp_pred` and `rsp_taken` low and returns `req_data` unchanged, for every operation kind.
- R6: For operation code 0 (conditional branch), and for code 3, which acts the same way, `rsp_taken` equals the predicate and `rsp_data` equals `req_data`.
- R7: For operation code 1 (set-on-condition), bits 7..0 of `rsp_data` are 0xFF when the predicate holds and 0x00 when it does not. Bits 31..8 are kept, and `rsp_taken` is low.
- R8: For operation code 2 (counted loop) with a false predicate, bits 15..0 are decremented modulo 2^16 and bits 31..16 are kept. `rsp_taken` is high exactly when the new low half is 0xFFFF.
- R9: For operation code 2 with a true predicate, `rsp_data` equals `req_data` and `rsp_taken` is low.
- R10: Results appear one cycle after a `req_valid` cycle, and `rsp_valid` is high for exactly those cycles. A request issued in the same cycle as a status write is judged on the flags stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_we | input | 1 | Status word write enable |
| stat_wdata | input | 32 | Status word write data |
| stat_rdata | output | 32 | Stored status word |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 branch, 1 set byte, 2 counted loop, 3 branch |
| req_code | input | 6 | Predicate code |
| req_data | input | 32 | Counter or destination register value |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_pred | output | 1 | Predicate outcome |
| rsp_illegal | output | 1 | Predicate code above 0x1F |
| rsp_data | output | 32 | Updated register value |
| rsp_taken | output | 1 | Branch taken |

## Verification
The assertions assume that `req_op`, `req_code` and `req_data` are stable during every cycle in which `req_valid` is high, since they compare outputs against the previous cycle's request. They also assume that reset is held for at least one clock edge before the first request. The stimulus always drives request fields together with the strobe on the falling edge, and it releases reset only after several edges. It covers every legal code against seven flag combinations, which include not-a-number with the masked flags set. It also covers illegal codes under every operation kind, a counter wrap from zero, and a request that coincides with a status write.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   // Operation kinds carried with each request
   typedef enum logic [1:0] {
      OP_BRANCH     = 2'b00,
      OP_SET        = 2'b01,
      OP_LOOP       = 2'b10,
      OP_BRANCH_ALT = 2'b11
   } fcc_op_e;

   // Condition flags used by the predicates (infinity is stored, never tested)
   typedef struct packed {
      logic neg;
      logic zero;
      logic nan;
   } fcc_cond_t;

   localparam int unsigned FLAG_CNT = 4;
   localparam int unsigned LEGAL_CODES = 32;

endpackage

// File: rtl/fcc_status_reg.sv
module fcc_status_reg
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned KEEP_W   = 24,
   parameter int unsigned FLAG_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output fcc_cond_t         cond
);

   localparam logic [DATA_W-1:0] LOW_MASK  = (DATA_W'(1) << KEEP_W) - DATA_W'(1);
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(4'hF) << FLAG_LSB;
   localparam logic [DATA_W-1:0] KEEP_MASK = LOW_MASK | FLAG_MASK;

   localparam int unsigned NAN_POS  = FLAG_LSB;
   localparam int unsigned ZERO_POS = FLAG_LSB + 2;
   localparam int unsigned NEG_POS  = FLAG_LSB + 3;

   if (KEEP_W > FLAG_LSB) begin : g_bad_keep
      $error("fcc_status_reg: kept field overlaps the flag field");
   end
   if (FLAG_LSB + FLAG_CNT > DATA_W) begin : g_bad_flags
      $error("fcc_status_reg: flag field exceeds the word");
   end

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (we) begin
         word_q <= wdata & KEEP_MASK;
      end
   end

   assign rdata     = word_q;
   assign cond.nan  = word_q[NAN_POS];
   assign cond.zero = word_q[ZERO_POS];
   assign cond.neg  = word_q[NEG_POS];

endmodule

// File: rtl/fcc_predicate.sv
module fcc_predicate
   import fcc_pkg::*;
#(
   parameter int unsigned CODE_W          = 6,
   parameter bit          FOLD_COMPLEMENT = 1'b1
) (
   input  fcc_cond_t         cond,
   input  logic [CODE_W-1:0] code,
   output logic              pred,
   output logic              illegal
);

   localparam logic [CODE_W-1:0] LAST_LEGAL = CODE_W'(LEGAL_CODES - 1);

   if (CODE_W < 6) begin : g_bad_code
      $error("fcc_predicate: code width must be at least 6");
   end

   logic u, z, n;
   logic raw;

   // Unordered masks the ordering flags
   always_comb begin
      u = cond.nan;
      z = cond.zero & ~cond.nan;
      n = cond.neg  & ~cond.nan;
   end

   if (FOLD_COMPLEMENT) begin : g_fold
      // Codes k and 15-k are complements: evaluate eight, invert by bit 3
      logic base;
      always_comb begin
         case (code[2:0] ^ {3{code[3]}})
            3'd0: base = 1'b0;
            3'd1: base = z;
            3'd2: base = ~(u | z | n);
            3'd3: base = z | ~(u | n);
            3'd4: base = n & ~(u | z);
            3'd5: base = z | (n & ~u);
            3'd6: base = ~(u | z);
            default: base = ~u;
         endcase
         raw = base ^ code[3];
      end
   end else begin : g_flat
      always_comb begin
         case (code[3:0])
            4'h0: raw = 1'b0;
            4'h1: raw = z;
            4'h2: raw = ~(u | z | n);
            4'h3: raw = z | ~(u | n);
            4'h4: raw = n & ~(u | z);
            4'h5: raw = z | (n & ~u);
            4'h6: raw = ~(u | z);
            4'h7: raw = ~u;
            4'h8: raw = u;
            4'h9: raw = u | z;
            4'hA: raw = u | ~(n | z);
            4'hB: raw = u | z | ~n;
            4'hC: raw = u | (n & ~z);
            4'hD: raw = u | z | n;
            4'hE: raw = ~z;
            default: raw = 1'b1;
         endcase
      end
   end

   // Bit 4 only selects the mirrored bank; anything above 0x1F is illegal
   assign illegal = (code > LAST_LEGAL);
   assign pred    = raw & ~illegal;

endmodule

// File: rtl/fcc_regupd.sv
module fcc_regupd
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned SET_W  = 8
) (
   input  fcc_op_e           op,
   input  logic              pred,
   input  logic              illegal,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              taken
);

   if (CNT_W >= DATA_W || CNT_W == 0) begin : g_bad_cnt
      $error("fcc_regupd: counter width must be within the register");
   end
   if (SET_W >= DATA_W || SET_W == 0) begin : g_bad_set
      $error("fcc_regupd: set field must be within the register");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_next;

   assign cnt_next = data_in[CNT_W-1:0] - CNT_ONE;

   always_comb begin
      data_out = data_in;
      taken    = 1'b0;
      if (!illegal) begin
         case (op)
            OP_SET: begin
               data_out = {data_in[DATA_W-1:SET_W], {SET_W{pred}}};
            end
            OP_LOOP: begin
               if (!pred) begin
                  data_out = {data_in[DATA_W-1:CNT_W], cnt_next};
                  taken    = &cnt_next;
               end
            end
            default: begin
               taken = pred;
            end
         endcase
      end
   end

endmodule

// File: rtl/fcc_eval.sv
module fcc_eval
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned CODE_W          = 6,
   parameter int unsigned CNT_W           = 16,
   parameter int unsigned SET_W           = 8,
   parameter int unsigned KEEP_W          = 24,
   parameter int unsigned FLAG_LSB        = 24,
   parameter bit          FOLD_COMPLEMENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] stat_wdata,
   output logic [DATA_W-1:0] stat_rdata,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [CODE_W-1:0] req_code,
   input  logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   output logic              rsp_pred,
   output logic              rsp_illegal,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_taken
);

   fcc_cond_t         cond;
   logic              pred_c;
   logic              illegal_c;
   logic [DATA_W-1:0] data_c;
   logic              taken_c;
   fcc_op_e           op_c;

   assign op_c = fcc_op_e'(req_op);

   fcc_status_reg #(
      .DATA_W   (DATA_W),
      .KEEP_W   (KEEP_W),
      .FLAG_LSB (FLAG_LSB)
   ) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (stat_we),
      .wdata (stat_wdata),
      .rdata (stat_rdata),
      .cond  (cond)
   );

   fcc_predicate #(
      .CODE_W          (CODE_W),
      .FOLD_COMPLEMENT (FOLD_COMPLEMENT)
   ) u_pred (
      .cond    (cond),
      .code    (req_code),
      .pred    (pred_c),
      .illegal (illegal_c)
   );

   fcc_regupd #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .SET_W  (SET_W)
   ) u_upd (
      .op       (op_c),
      .pred     (pred_c),
      .illegal  (illegal_c),
      .data_in  (req_data),
      .data_out (data_c),
      .taken    (taken_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_pred    <= 1'b0;
         rsp_illegal <= 1'b0;
         rsp_data    <= '0;
         rsp_taken   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_pred    <= pred_c;
            rsp_illegal <= illegal_c;
            rsp_data    <= data_c;
            rsp_taken   <= taken_c;
         end
      end
   end

endmodule

// File: rtl/fcc_eval_chk.sv
module fcc_eval_chk
   import fcc_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CODE_W   = 6,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned SET_W    = 8,
   parameter int unsigned KEEP_W   = 24,
   parameter int unsigned FLAG_LSB = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stat_we,
   input logic [DATA_W-1:0] stat_wdata,
   input logic [DATA_W-1:0] stat_rdata,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [CODE_W-1:0] req_code,
   input logic [DATA_W-1:0] req_data,
   input logic              rsp_valid,
   input logic              rsp_pred,
   input logic              rsp_illegal,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_taken
);

   localparam logic [DATA_W-1:0] WMASK =
      ((DATA_W'(1) << KEEP_W) - DATA_W'(1)) | (DATA_W'(4'hF) << FLAG_LSB);
   localparam logic [CODE_W-1:0] NAN_CODE = CODE_W'(8);

   // R1: a write is visible, masked, on the next cycle
   a_r1_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |=> stat_rdata == ($past(stat_wdata) & WMASK));

   // R10: result strobe follows the request strobe by one cycle
   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R5: illegal code leaves everything quiet
   a_r5_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |->
         (!rsp_pred && !rsp_taken && rsp_data == $past(req_data)));

   // R3: code 0x08 reports the stored not-a-number flag
   a_r3_unordered_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_code) == NAN_CODE) |->
         rsp_pred == $past(stat_rdata[FLAG_LSB]));

   // R6: branch kinds pass data through and take on the predicate
   a_r6_branch: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_illegal && !$past(req_op[1] ^ req_op[0])) |->
         (rsp_taken == rsp_pred && rsp_data == $past(req_data)));

   // R7: set-on-condition writes a byte mask and keeps the rest
   a_r7_set_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_illegal && $past(req_op) == 2'b01) |->
         (rsp_data[SET_W-1:0] == {SET_W{rsp_pred}} && !rsp_taken &&
          rsp_data[DATA_W-1:SET_W] == $past(req_data[DATA_W-1:SET_W])));

   // R8: loop branch only on wrap to all ones, upper half kept
   a_r8_wrap_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_taken && $past(req_op) == 2'b10) |->
         (&rsp_data[CNT_W-1:0] && !rsp_pred &&
          rsp_data[DATA_W-1:CNT_W] == $past(req_data[DATA_W-1:CNT_W])));

   // R9: loop with a true predicate leaves the counter alone
   a_r9_loop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_pred && $past(req_op) == 2'b10) |->
         (rsp_data == $past(req_data) && !rsp_taken));

endmodule

bind fcc_eval fcc_eval_chk #(
   .DATA_W   (DATA_W),
   .CODE_W   (CODE_W),
   .CNT_W    (CNT_W),
   .SET_W    (SET_W),
   .KEEP_W   (KEEP_W),
   .FLAG_LSB (FLAG_LSB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stat_we     (stat_we),
   .stat_wdata  (stat_wdata),
   .stat_rdata  (stat_rdata),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .req_code    (req_code),
   .req_data    (req_data),
   .rsp_valid   (rsp_valid),
   .rsp_pred    (rsp_pred),
   .rsp_illegal (rsp_illegal),
   .rsp_data    (rsp_data),
   .rsp_taken   (rsp_taken)
);

// File: tb/sim_fcc_eval.sv
module sim_fcc_eval;

   typedef struct {
      logic        pred;
      logic        ill;
      logic        taken;
      logic [31:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stat_we = 1'b0;
   logic [31:0] stat_wdata = '0;
   logic [31:0] stat_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [5:0]  req_code = '0;
   logic [31:0] req_data = '0;
   logic        rsp_valid, rsp_pred, rsp_illegal, rsp_taken;
   logic [31:0] rsp_data;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   exp_t sb[$];

   // model flags
   logic m_nan = 0, m_zero = 0, m_neg = 0;

   always #10 clk = ~clk;

   fcc_eval u0 (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
      .stat_rdata(stat_rdata), .req_valid(req_valid), .req_op(req_op),
      .req_code(req_code), .req_data(req_data), .rsp_valid(rsp_valid),
      .rsp_pred(rsp_pred), .rsp_illegal(rsp_illegal), .rsp_data(rsp_data),
      .rsp_taken(rsp_taken)
   );

   function automatic logic exp_pred(input logic [5:0] code);
      logic u, z, n;
      u = m_nan; z = m_zero & ~m_nan; n = m_neg & ~m_nan;
      case (code[3:0])
         4'h0: return 1'b0;        4'h1: return z;
         4'h2: return !(u|z|n);    4'h3: return z | !(u|n);
         4'h4: return n & !(u|z);  4'h5: return z | (n & !u);
         4'h6: return !(u|z);      4'h7: return !u;
         4'h8: return u;           4'h9: return u | z;
         4'hA: return u | !(n|z);  4'hB: return u | z | !n;
         4'hC: return u | (n & !z);4'hD: return u | z | n;
         4'hE: return !z;          default: return 1'b1;
      endcase
   endfunction

   function automatic exp_t model(input logic [1:0] op, input logic [5:0] code,
                                  input logic [31:0] d, input string tag);
      exp_t e;
      logic [15:0] c;
      e.tag = tag; e.ill = (code > 6'h1F); e.data = d; e.taken = 1'b0;
      e.pred = e.ill ? 1'b0 : exp_pred(code);
      if (!e.ill) begin
         if (op == 2'b01) e.data = {d[31:8], (e.pred ? 8'hFF : 8'h00)};
         else if (op == 2'b10) begin
            if (!e.pred) begin
               c = d[15:0] - 16'd1;
               e.data = {d[31:16], c};
               e.taken = (c == 16'hFFFF);
            end
         end else e.taken = e.pred;
      end
      return e;
   endfunction

   // monitor: compare each result as it appears
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         exp_t e;
         tests++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected result: got valid, expected none");
         end else begin
            e = sb.pop_front();
            if (rsp_pred !== e.pred || rsp_illegal !== e.ill ||
                rsp_taken !== e.taken || rsp_data !== e.data) begin
               fails++;
               $display("FAIL %s: got pred=%0b ill=%0b taken=%0b data=%h, expected pred=%0b ill=%0b taken=%0b data=%h",
                        e.tag, rsp_pred, rsp_illegal, rsp_taken, rsp_data,
                        e.pred, e.ill, e.taken, e.data);
            end
         end
      end
   end

   task automatic check(input bit ok, input string msg, input logic [31:0] got,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", msg, got, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [5:0] code,
                        input logic [31:0] d, input string tag);
      @(negedge clk);
      stat_we = 1'b0;
      req_valid = 1'b1; req_op = op; req_code = code; req_data = d;
      sb.push_back(model(op, code, d, tag));
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; stat_we = 1'b0;
   endtask

   task automatic wr_stat(input logic [31:0] v);
      @(negedge clk);
      req_valid = 1'b0;
      stat_we = 1'b1; stat_wdata = v;
      @(negedge clk);
      stat_we = 1'b0;
      m_nan = v[24]; m_zero = v[26]; m_neg = v[27];
      check(stat_rdata === (v & 32'h0FFF_FFFF), "R1 status readback",
            stat_rdata, v & 32'h0FFF_FFFF);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      logic [3:0] pats [7];
      pats[0] = 4'b0000; pats[1] = 4'b1000; pats[2] = 4'b0100; pats[3] = 4'b0010;
      pats[4] = 4'b0001; pats[5] = 4'b1101; pats[6] = 4'b1100;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0 && rsp_data === 32'h0 && rsp_taken === 1'b0,
            "R10 reset outputs", rsp_data, 32'h0);
      check(stat_rdata === 32'h0, "R1 reset status", stat_rdata, 32'h0);

      // R1: bits 31..28 dropped
      wr_stat(32'hF0AB_CDEF);

      // R3 R4 R2: all legal codes under several flag mixes (R2: pattern 1101)
      for (int p = 0; p < 7; p++) begin
         wr_stat({4'h0, pats[p], 24'h12_3456});
         for (int c = 0; c < 32; c++)
            issue(2'b00, 6'(c), 32'hA5A5_0000 | 32'(c),
                  (c < 16) ? "R3 predicate table" : "R4 mirrored code");
         idle();
      end

      // R6 alias op 3, R2 infinity only
      wr_stat(32'h0200_0000);
      issue(2'b11, 6'h0E, 32'hDEAD_BEEF, "R6 op3 branch");
      issue(2'b11, 6'h01, 32'h0000_0001, "R2 infinity ignored");

      // R7 set byte with Z set
      wr_stat(32'h0400_0000);
      issue(2'b01, 6'h01, 32'h1234_5600, "R7 set true");
      issue(2'b01, 6'h1E, 32'hCAFE_F0A5, "R7 set false");

      // R8 R9 counted loop, Z set: code 0 false, 0x11 true
      issue(2'b10, 6'h00, 32'h1234_0000, "R8 loop wrap taken");
      issue(2'b10, 6'h00, 32'h1234_0005, "R8 loop decrement");
      issue(2'b10, 6'h10, 32'hFFFF_0001, "R8 loop to zero");
      issue(2'b10, 6'h11, 32'h5555_0000, "R9 loop true holds");
      issue(2'b10, 6'h0F, 32'h0000_0003, "R9 loop true holds");

      // R5 illegal codes under every op
      issue(2'b00, 6'h20, 32'h0000_00FF, "R5 illegal branch");
      issue(2'b01, 6'h3F, 32'h8765_4321, "R5 illegal set");
      issue(2'b10, 6'h2F, 32'h0000_0000, "R5 illegal loop");
      issue(2'b11, 6'h30, 32'h1111_2222, "R5 illegal alt");
      idle();

      // R10: request with concurrent write uses the old flags (Z set now)
      @(negedge clk);
      stat_we = 1'b1; stat_wdata = 32'h0100_0000;
      req_valid = 1'b1; req_op = 2'b00; req_code = 6'h01; req_data = 32'h77;
      sb.push_back(model(2'b00, 6'h01, 32'h77, "R10 old flags used"));
      @(negedge clk);
      stat_we = 1'b0; req_valid = 1'b0;
      m_nan = 1'b1; m_zero = 1'b0; m_neg = 1'b0;
      issue(2'b00, 6'h08, 32'h88, "R10 new flags after write");
      idle();

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R10 all results delivered", 32'(sb.size()), 32'h0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule